// File: doc/BRIEF.md
# Branch Next-Address Unit

This block works out where an 8-bit controller goes after a control-transfer instruction. In one cycle it takes the address of the instruction, its opcode and up to two operand bytes, plus the accumulator, the carry flag, a 16-bit pointer, a counter or direct byte and a tested bit. One clock edge later it presents the next program address, whether the branch was taken and how long the instruction is. For loop instructions it also gives the decremented count with a write enable. For compare instructions it gives the new carry with a write enable.

Five ways of forming a target are covered: a full 16-bit address, an 11-bit offset inside the current 2 KB page, a signed offset from the end of the instruction, the pointer plus the accumulator, and decrement or compare loops. Fetch, call and return handling, and bit storage stay outside; the tested bit arrives as an input. The block is one register stage: every output is a registered copy of the combinational result for the inputs seen at the previous rising edge.

Top module: `bnu_next_pc`

## Requirements
- R1: While rst_n is low, next_pc_o, taken_o, len_o, cnt_o, cnt_we_o, carry_o and carry_we_o are all zero.
- R2: Opcode 02h is a 3-byte long jump. It is always taken, and its target is {op1_i, op2_i} (op1_i is the high byte).
- R3: An opcode whose low five bits are 00001b is a 2-byte in-page jump. It is always taken. Its target keeps bits 15:11 of pc_i+2, and bits 10:0 come from opcode bits 7:5 followed by op1_i.
- R4: Opcode 80h is a 2-byte short jump. It is always taken, and its target is pc_i+2 plus op1_i read as a signed 8-bit value.
- R5: Opcode 73h is a 1-byte indirect jump. It is always taken, and its target is ptr_i plus acc_i, zero-extended.
- R6: Opcodes 60h (taken when acc_i is zero) and 70h (taken when acc_i is non-zero) are 2 bytes long. The offset is op1_i.
- R7: Opcodes 40h (taken when carry_i is 1) and 50h (taken when carry_i is 0) are 2 bytes long. The offset is op1_i.
- R8: Opcodes 20h (taken when bit_i is 1) and 30h (taken when bit_i is 0) are 3 bytes long. The offset is op2_i.
- R9: Opcodes D8h (2 bytes, offset op1_i) and D5h (3 bytes, offset op2_i) give cnt_o = byte_i-1 modulo 256 with cnt_we_o = 1. They are taken when cnt_o is non-zero, so byte_i = 00h wraps to FFh and is taken.
- R10: Opcodes B4h (second operand op1_i) and B5h (second operand byte_i) are 3 bytes long, with the offset in op2_i. They are taken when acc_i differs from the second operand. They set carry_we_o = 1 and carry_o = 1 exactly when acc_i is below the second operand, compared unsigned.
- R11: A conditional branch that is not taken gives next_pc_o = pc_i + len_o. A taken relative branch adds the signed offset to that value. All address sums wrap modulo 65536.
- R12: Any other opcode gives len_o = 1, taken_o = 0 and next_pc_o = pc_i+1, with both write enables low.
- R13: Outputs change only at a rising clock edge and reflect the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pc_i | input | 16 | Address of the instruction |
| opcode_i | input | 8 | Opcode byte |
| op1_i | input | 8 | First operand byte |
| op2_i | input | 8 | Second operand byte |
| acc_i | input | 8 | Accumulator value |
| carry_i | input | 1 | Current carry flag |
| ptr_i | input | 16 | Data pointer for the indirect jump |
| byte_i | input | 8 | Counter register or direct byte value |
| bit_i | input | 1 | Bit tested by the bit-jump opcodes |
| next_pc_o | output | 16 | Next program address |
| taken_o | output | 1 | Branch taken |
| len_o | output | 2 | Instruction length in bytes |
| cnt_o | output | 8 | Decremented count |
| cnt_we_o | output | 1 | Write enable for cnt_o |
| carry_o | output | 1 | New carry from a compare |
| carry_we_o | output | 1 | Write enable for carry_o |

## Verification
In a compare instruction, the carry update and the branch decision come from the same pair of operands in the same cycle. A decrement instruction likewise produces its write-back and its decision together. The bench drives acc_i below, above and equal to each second-operand source, and checks carry_o, taken_o and next_pc_o together. A property also checks that a set carry never appears without a taken branch. The decrement is exercised at counts of 1 and 0, so that the write-back value and the decision both move across the zero boundary.

// File: rtl/bnu_pkg.sv
package bnu_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 2;
    localparam int PAGE_W = 11;

    localparam logic [DATA_W-1:0] OPC_LONG   = 8'h02;
    localparam logic [4:0]        OPC_PAGE_L = 5'b00001;
    localparam logic [DATA_W-1:0] OPC_SHORT  = 8'h80;
    localparam logic [DATA_W-1:0] OPC_INDIR  = 8'h73;
    localparam logic [DATA_W-1:0] OPC_ACCZ   = 8'h60;
    localparam logic [DATA_W-1:0] OPC_ACCNZ  = 8'h70;
    localparam logic [DATA_W-1:0] OPC_CY     = 8'h40;
    localparam logic [DATA_W-1:0] OPC_NCY    = 8'h50;
    localparam logic [DATA_W-1:0] OPC_BSET   = 8'h20;
    localparam logic [DATA_W-1:0] OPC_BCLR   = 8'h30;
    localparam logic [DATA_W-1:0] OPC_DECR   = 8'hD8;
    localparam logic [DATA_W-1:0] OPC_DECB   = 8'hD5;
    localparam logic [DATA_W-1:0] OPC_CMPI   = 8'hB4;
    localparam logic [DATA_W-1:0] OPC_CMPB   = 8'hB5;

    typedef enum logic [3:0] {
        K_NONE, K_LONG, K_PAGE, K_SHORT, K_INDIR,
        K_ACCZ, K_ACCNZ, K_CY, K_NCY, K_BSET, K_BCLR,
        K_DECR, K_CMP
    } kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] next_pc;
        logic              taken;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] cnt_new;
        logic              cnt_we;
        logic              carry_new;
        logic              carry_we;
    } result_t;

endpackage

// File: rtl/bnu_decode.sv
module bnu_decode
    import bnu_pkg::*;
(
    input  logic [DATA_W-1:0] opcode_i,
    output kind_e             kind_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              rel_op2_o,
    output logic              cmp_byte_o
);

    always_comb begin
        kind_o     = K_NONE;
        len_o      = LEN_W'(1);
        cmp_byte_o = 1'b0;
        if (opcode_i[4:0] == OPC_PAGE_L) begin
            kind_o = K_PAGE;
            len_o  = LEN_W'(2);
        end else begin
            unique case (opcode_i)
                OPC_LONG:  begin kind_o = K_LONG;  len_o = LEN_W'(3); end
                OPC_SHORT: begin kind_o = K_SHORT; len_o = LEN_W'(2); end
                OPC_INDIR: begin kind_o = K_INDIR; len_o = LEN_W'(1); end
                OPC_ACCZ:  begin kind_o = K_ACCZ;  len_o = LEN_W'(2); end
                OPC_ACCNZ: begin kind_o = K_ACCNZ; len_o = LEN_W'(2); end
                OPC_CY:    begin kind_o = K_CY;    len_o = LEN_W'(2); end
                OPC_NCY:   begin kind_o = K_NCY;   len_o = LEN_W'(2); end
                OPC_BSET:  begin kind_o = K_BSET;  len_o = LEN_W'(3); end
                OPC_BCLR:  begin kind_o = K_BCLR;  len_o = LEN_W'(3); end
                OPC_DECR:  begin kind_o = K_DECR;  len_o = LEN_W'(2); end
                OPC_DECB:  begin kind_o = K_DECR;  len_o = LEN_W'(3); end
                OPC_CMPI:  begin kind_o = K_CMP;   len_o = LEN_W'(3); end
                OPC_CMPB:  begin kind_o = K_CMP;   len_o = LEN_W'(3); cmp_byte_o = 1'b1; end
                default:   begin kind_o = K_NONE;  len_o = LEN_W'(1); end
            endcase
        end
    end

    // Relative offsets sit in the last operand byte of the instruction.
    assign rel_op2_o = (len_o == LEN_W'(3));

endmodule

// File: rtl/bnu_target.sv
module bnu_target
    import bnu_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [2:0]        page_sel_i,
    input  logic [DATA_W-1:0] op1_i,
    input  logic [DATA_W-1:0] op2_i,
    input  logic              rel_op2_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] rel_o,
    output logic [ADDR_W-1:0] long_o,
    output logic [ADDR_W-1:0] page_o,
    output logic [ADDR_W-1:0] indir_o
);

    localparam int HI_W = ADDR_W - PAGE_W;

    logic [DATA_W-1:0] rel_byte;
    logic [ADDR_W-1:0] rel_ext;
    logic [ADDR_W-1:0] pc_p2;

    assign rel_byte = rel_op2_i ? op2_i : op1_i;
    assign rel_ext  = {{(ADDR_W-DATA_W){rel_byte[DATA_W-1]}}, rel_byte};

    assign seq_o   = pc_i + {{(ADDR_W-LEN_W){1'b0}}, len_i};
    assign rel_o   = seq_o + rel_ext;
    assign long_o  = {op1_i, op2_i};
    assign pc_p2   = pc_i + ADDR_W'(2);
    assign page_o  = {pc_p2[ADDR_W-1 -: HI_W], page_sel_i, op1_i};
    assign indir_o = ptr_i + {{(ADDR_W-DATA_W){1'b0}}, acc_i};

endmodule

// File: rtl/bnu_cond.sv
module bnu_cond
    import bnu_pkg::*;
(
    input  kind_e             kind_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              carry_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] cmp_other_i,
    output logic              take_o,
    output logic [DATA_W-1:0] cnt_new_o,
    output logic              cnt_we_o,
    output logic              carry_new_o,
    output logic              carry_we_o
);

    logic [DATA_W-1:0] dec_val;
    logic              acc_zero;
    logic              acc_below;

    assign dec_val   = cnt_i - DATA_W'(1);
    assign acc_zero  = (acc_i == '0);
    assign acc_below = (acc_i < cmp_other_i);

    always_comb begin
        take_o      = 1'b0;
        cnt_new_o   = '0;
        cnt_we_o    = 1'b0;
        carry_new_o = 1'b0;
        carry_we_o  = 1'b0;
        unique case (kind_i)
            K_ACCZ:  take_o = acc_zero;
            K_ACCNZ: take_o = !acc_zero;
            K_CY:    take_o = carry_i;
            K_NCY:   take_o = !carry_i;
            K_BSET:  take_o = bit_i;
            K_BCLR:  take_o = !bit_i;
            K_DECR: begin
                cnt_new_o = dec_val;
                cnt_we_o  = 1'b1;
                take_o    = (dec_val != '0);
            end
            K_CMP: begin
                take_o      = (acc_i != cmp_other_i);
                carry_new_o = acc_below;
                carry_we_o  = 1'b1;
            end
            default: take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnu_next_pc.sv
module bnu_next_pc
    import bnu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] opcode_i,
    input  logic [DATA_W-1:0] op1_i,
    input  logic [DATA_W-1:0] op2_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              carry_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              bit_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              taken_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              cnt_we_o,
    output logic              carry_o,
    output logic              carry_we_o
);

    kind_e             kind;
    logic [LEN_W-1:0]  len;
    logic              rel_op2;
    logic              cmp_byte;
    logic [ADDR_W-1:0] tgt_seq, tgt_rel, tgt_long, tgt_page, tgt_indir;
    logic              take;
    logic [DATA_W-1:0] cnt_new;
    logic              cnt_we, carry_new, carry_we;
    logic [DATA_W-1:0] cmp_other;

    result_t res_d, res_q;

    bnu_decode i_decode (
        .opcode_i   (opcode_i),
        .kind_o     (kind),
        .len_o      (len),
        .rel_op2_o  (rel_op2),
        .cmp_byte_o (cmp_byte)
    );

    bnu_target i_target (
        .pc_i       (pc_i),
        .len_i      (len),
        .page_sel_i (opcode_i[7:5]),
        .op1_i      (op1_i),
        .op2_i      (op2_i),
        .rel_op2_i  (rel_op2),
        .acc_i      (acc_i),
        .ptr_i      (ptr_i),
        .seq_o      (tgt_seq),
        .rel_o      (tgt_rel),
        .long_o     (tgt_long),
        .page_o     (tgt_page),
        .indir_o    (tgt_indir)
    );

    assign cmp_other = cmp_byte ? byte_i : op1_i;

    bnu_cond i_cond (
        .kind_i      (kind),
        .acc_i       (acc_i),
        .carry_i     (carry_i),
        .bit_i       (bit_i),
        .cnt_i       (byte_i),
        .cmp_other_i (cmp_other),
        .take_o      (take),
        .cnt_new_o   (cnt_new),
        .cnt_we_o    (cnt_we),
        .carry_new_o (carry_new),
        .carry_we_o  (carry_we)
    );

    always_comb begin
        res_d           = '0;
        res_d.len       = len;
        res_d.next_pc   = tgt_seq;
        res_d.cnt_new   = cnt_new;
        res_d.cnt_we    = cnt_we;
        res_d.carry_new = carry_new;
        res_d.carry_we  = carry_we;
        unique case (kind)
            K_NONE:  res_d.taken = 1'b0;
            K_LONG:  begin res_d.taken = 1'b1; res_d.next_pc = tgt_long;  end
            K_PAGE:  begin res_d.taken = 1'b1; res_d.next_pc = tgt_page;  end
            K_SHORT: begin res_d.taken = 1'b1; res_d.next_pc = tgt_rel;   end
            K_INDIR: begin res_d.taken = 1'b1; res_d.next_pc = tgt_indir; end
            default: begin
                res_d.taken   = take;
                res_d.next_pc = take ? tgt_rel : tgt_seq;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign next_pc_o  = res_q.next_pc;
    assign taken_o    = res_q.taken;
    assign len_o      = res_q.len;
    assign cnt_o      = res_q.cnt_new;
    assign cnt_we_o   = res_q.cnt_we;
    assign carry_o    = res_q.carry_new;
    assign carry_we_o = res_q.carry_we;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (res_q == '0)); // R1

    AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode_i) == OPC_LONG)
        |-> (taken_o && next_pc_o == {$past(op1_i), $past(op2_i)})); // R2

    AST_DEC_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_o |-> (taken_o == (cnt_o != '0))); // R9

    AST_CARRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we_o && carry_o) |-> (taken_o && len_o == LEN_W'(3))); // R10

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_we_o, carry_we_o})); // R10

    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o)
        |-> (next_pc_o == $past(pc_i) + {{(ADDR_W-LEN_W){1'b0}}, len_o})); // R11

    AST_LEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (len_o != '0)); // R12

endmodule

// File: tb/test_bnu_next_pc.sv
module test_bnu_next_pc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  opcode_i = '0, op1_i = '0, op2_i = '0, acc_i = '0, byte_i = '0;
    logic        carry_i = 1'b0, bit_i = 1'b0;
    logic [15:0] ptr_i = '0;
    logic [15:0] next_pc_o;
    logic        taken_o, cnt_we_o, carry_o, carry_we_o;
    logic [1:0]  len_o;
    logic [7:0]  cnt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bnu_next_pc i_bnu_next_pc (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .opcode_i(opcode_i),
        .op1_i(op1_i), .op2_i(op2_i), .acc_i(acc_i), .carry_i(carry_i),
        .ptr_i(ptr_i), .byte_i(byte_i), .bit_i(bit_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .len_o(len_o),
        .cnt_o(cnt_o), .cnt_we_o(cnt_we_o), .carry_o(carry_o),
        .carry_we_o(carry_we_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge; the result is sampled at the next falling edge.
    task automatic run(input logic [7:0] opc, input logic [15:0] pc,
                       input logic [7:0] o1, input logic [7:0] o2);
        @(negedge clk);
        opcode_i = opc; pc_i = pc; op1_i = o1; op2_i = o2;
        @(negedge clk);
    endtask

    task automatic expect_br(input string tag, input logic [15:0] npc,
                             input logic tk, input logic [1:0] ln);
        chk(tag, "next_pc", next_pc_o, npc);
        chk(tag, "taken", {15'b0, taken_o}, {15'b0, tk});
        chk(tag, "len", {14'b0, len_o}, {14'b0, ln});
    endtask

    task automatic t_reset;
        chk("R1", "next_pc", next_pc_o, 16'h0);
        chk("R1", "taken", {15'b0, taken_o}, 16'h0);
        chk("R1", "len", {14'b0, len_o}, 16'h0);
        chk("R1", "writes", {12'b0, cnt_we_o, carry_we_o, carry_o, 1'b0}, 16'h0);
        chk("R1", "cnt", {8'b0, cnt_o}, 16'h0);
    endtask

    task automatic t_long;
        run(8'h02, 16'h1234, 8'hAB, 8'hCD);
        expect_br("R2", 16'hABCD, 1'b1, 2'd3);
        chk("R2", "no writes", {14'b0, cnt_we_o, carry_we_o}, 16'h0);
    endtask

    task automatic t_page;
        run(8'hA1, 16'h1234, 8'h56, 8'h00);
        expect_br("R3", 16'h1556, 1'b1, 2'd2);
        run(8'h21, 16'h07FE, 8'h10, 8'h00);   // pc+2 lands in the next page
        expect_br("R3", 16'h0910, 1'b1, 2'd2);
    endtask

    task automatic t_short;
        run(8'h80, 16'h0100, 8'h10, 8'h00);
        expect_br("R4", 16'h0112, 1'b1, 2'd2);
        run(8'h80, 16'h0100, 8'hFE, 8'h00);
        expect_br("R4", 16'h0100, 1'b1, 2'd2);
        run(8'h80, 16'hFFFF, 8'h05, 8'h00);
        expect_br("R4", 16'h0006, 1'b1, 2'd2);
        run(8'h80, 16'h0000, 8'h80, 8'h00);
        expect_br("R4", 16'hFF82, 1'b1, 2'd2);
    endtask

    task automatic t_indir;
        ptr_i = 16'h2000; acc_i = 8'h34;
        run(8'h73, 16'h0500, 8'h00, 8'h00);
        expect_br("R5", 16'h2034, 1'b1, 2'd1);
        ptr_i = 16'hFFF0; acc_i = 8'h20;
        run(8'h73, 16'h0500, 8'h00, 8'h00);
        expect_br("R5", 16'h0010, 1'b1, 2'd1);
    endtask

    task automatic t_acc;
        acc_i = 8'h00; run(8'h60, 16'h0200, 8'h08, 8'h00);
        expect_br("R6", 16'h020A, 1'b1, 2'd2);
        acc_i = 8'h05; run(8'h60, 16'h0200, 8'h08, 8'h00);
        expect_br("R6", 16'h0202, 1'b0, 2'd2);
        acc_i = 8'h05; run(8'h70, 16'h0200, 8'h08, 8'h00);
        expect_br("R6", 16'h020A, 1'b1, 2'd2);
        acc_i = 8'h00; run(8'h70, 16'h0200, 8'h08, 8'h00);
        expect_br("R6", 16'h0202, 1'b0, 2'd2);
    endtask

    task automatic t_carry;
        carry_i = 1'b1; run(8'h40, 16'h0250, 8'hF0, 8'h00);
        expect_br("R7", 16'h0242, 1'b1, 2'd2);
        carry_i = 1'b0; run(8'h40, 16'h0250, 8'hF0, 8'h00);
        expect_br("R7", 16'h0252, 1'b0, 2'd2);
        carry_i = 1'b0; run(8'h50, 16'h0250, 8'hF0, 8'h00);
        expect_br("R7", 16'h0242, 1'b1, 2'd2);
        carry_i = 1'b1; run(8'h50, 16'h0250, 8'hF0, 8'h00);
        expect_br("R7", 16'h0252, 1'b0, 2'd2);
    endtask

    task automatic t_bit;
        bit_i = 1'b1; run(8'h20, 16'h0300, 8'h33, 8'h10);
        expect_br("R8", 16'h0313, 1'b1, 2'd3);
        bit_i = 1'b0; run(8'h20, 16'h0300, 8'h33, 8'h10);
        expect_br("R8", 16'h0303, 1'b0, 2'd3);
        bit_i = 1'b0; run(8'h30, 16'h0300, 8'h33, 8'h10);
        expect_br("R8", 16'h0313, 1'b1, 2'd3);
    endtask

    task automatic t_dec;
        byte_i = 8'h05; run(8'hD8, 16'h0400, 8'hFC, 8'h00);
        expect_br("R9", 16'h03FE, 1'b1, 2'd2);
        chk("R9", "cnt", {8'b0, cnt_o}, 16'h0004);
        chk("R9", "cnt_we", {15'b0, cnt_we_o}, 16'h1);
        byte_i = 8'h01; run(8'hD8, 16'h0400, 8'hFC, 8'h00);
        expect_br("R9", 16'h0402, 1'b0, 2'd2);
        chk("R9", "cnt to zero", {8'b0, cnt_o}, 16'h0000);
        byte_i = 8'h00; run(8'hD8, 16'h0400, 8'hFC, 8'h00);
        expect_br("R9", 16'h03FE, 1'b1, 2'd2);
        chk("R9", "cnt wrap", {8'b0, cnt_o}, 16'h00FF);
        byte_i = 8'h03; run(8'hD5, 16'h0400, 8'h7F, 8'hF0);
        expect_br("R9", 16'h03F3, 1'b1, 2'd3);
        chk("R9", "cnt byte", {8'b0, cnt_o}, 16'h0002);
        chk("R9", "carry_we", {15'b0, carry_we_o}, 16'h0);
    endtask

    task automatic t_cmp;
        acc_i = 8'h10; run(8'hB4, 16'h0500, 8'h20, 8'h05);
        expect_br("R10", 16'h0508, 1'b1, 2'd3);
        chk("R10", "carry below", {14'b0, carry_we_o, carry_o}, 16'h0003);
        acc_i = 8'h30; run(8'hB4, 16'h0500, 8'h20, 8'h05);
        expect_br("R10", 16'h0508, 1'b1, 2'd3);
        chk("R10", "carry above", {14'b0, carry_we_o, carry_o}, 16'h0002);
        acc_i = 8'h20; run(8'hB4, 16'h0500, 8'h20, 8'h05);
        expect_br("R10", 16'h0503, 1'b0, 2'd3);
        chk("R10", "carry equal", {14'b0, carry_we_o, carry_o}, 16'h0002);
        acc_i = 8'h10; byte_i = 8'h10; run(8'hB5, 16'h0500, 8'h20, 8'h05);
        expect_br("R10", 16'h0503, 1'b0, 2'd3);
        chk("R10", "byte source", {14'b0, carry_we_o, carry_o}, 16'h0002);
        chk("R10", "cnt_we", {15'b0, cnt_we_o}, 16'h0);
    endtask

    task automatic t_fall;
        carry_i = 1'b0; run(8'h40, 16'hFFFF, 8'h10, 8'h00);
        expect_br("R11", 16'h0001, 1'b0, 2'd2);
        bit_i = 1'b1; run(8'h30, 16'hFFFE, 8'h00, 8'h10);
        expect_br("R11", 16'h0001, 1'b0, 2'd3);
    endtask

    task automatic t_other;
        run(8'h00, 16'h0600, 8'h11, 8'h22);
        expect_br("R12", 16'h0601, 1'b0, 2'd1);
        chk("R12", "writes", {14'b0, cnt_we_o, carry_we_o}, 16'h0);
        run(8'hFF, 16'hFFFF, 8'h11, 8'h22);
        expect_br("R12", 16'h0000, 1'b0, 2'd1);
    endtask

    task automatic t_latency;
        run(8'h02, 16'h0000, 8'h11, 8'h11);
        @(negedge clk);
        opcode_i = 8'h02; op1_i = 8'h22; op2_i = 8'h22;
        #2;
        chk("R13", "held before edge", next_pc_o, 16'h1111);
        @(negedge clk);
        chk("R13", "after edge", next_pc_o, 16'h2222);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_long();
        t_page();
        t_short();
        t_indir();
        t_acc();
        t_carry();
        t_bit();
        t_dec();
        t_cmp();
        t_fall();
        t_other();
        t_latency();
        finish_run();
    end

endmodule